// File: doc/BRIEF.md
# Tri-State Phase Detector Output Stage

This block watches two pulse trains, a reference and a divided feedback, and decides on every rising edge which one arrived first. It keeps two internal flags, UP (the reference edge came first) and DOWN (the feedback edge came first). When the matching edge on the other input arrives, both flags clear, so only the gap between the two edges is reported. Both inputs are sampled in the block clock domain, and a rising edge is a sample at 1 that follows a sample at 0.

The flags drive three error outputs. Each pin is modelled as a drive value plus an output enable, so the high-impedance state can be seen directly. The first is a combined tri-state output that drives high for UP, drives low for DOWN, and floats when neither flag is set. The other two are open-drain enables for an external active filter. The pull-up side is active for UP and the pull-down side is active for DOWN. A 2-bit selection code enables the combined output and the external pair independently. A power-save input and a forced-reset input each push every output to off at once. While either input is high, the detector is also held clear.

The block has no data stream. All pins are plain control and status levels with no handshake, and no back-pressure applies.

Top module: `pd_out_stage`

## Requirements
- R1: A reference rising edge with no DOWN pending sets UP at the next clock edge. A feedback rising edge with no UP pending sets DOWN at the next clock edge.
- R2: An edge that arrives while the opposite flag is pending clears both flags at the next clock edge. UP and DOWN are never set together.
- R3: Rising edges on both inputs in the same cycle leave both flags clear at the next clock edge, whatever state came before.
- R4: When cp_sel[1]=1 the combined output is enabled only while a flag is set. It drives 1 for UP and 0 for DOWN. When no flag is set, cmb_oe=0 (high impedance).
- R5: When cp_sel[0]=1, pup_oe=1 exactly while UP is set and pdn_oe=1 exactly while DOWN is set. The two are never on together.
- R6: Selection codes: 00 turns off both groups, 01 enables only the external pair, 10 enables only the combined output, and 11 enables both. A disabled group stays off whatever the flags are.
- R7: While pwr_save=1, all three outputs are off in the same cycle. The flags are held clear, and edges seen during power-save leave no flag after it ends.
- R8: While force_rst=1, all three outputs are off in the same cycle and the flags are held clear.
- R9: After rst_n is released, all outputs are off and both flags are clear.
- R10: An input held at 1 counts as one edge only. Holding it high does not set a flag again after the flags have cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference pulse train |
| fb_in | input | 1 | Divided feedback pulse train |
| cp_sel | input | 2 | Bit 1 enables the combined output, bit 0 enables the external pair |
| pwr_save | input | 1 | High: power-save, all outputs off, detector held clear |
| force_rst | input | 1 | High: forced reset, all outputs off, detector held clear |
| cmb_drv | output | 1 | Combined output drive value (1 = high, 0 = low) |
| cmb_oe | output | 1 | Combined output enable (0 = high impedance) |
| pup_oe | output | 1 | Pull-up open-drain enable |
| pdn_oe | output | 1 | Pull-down open-drain enable |

## Verification
Two events can land in the same cycle. The first is a new edge on one input while the opposite flag is pending, or edges on both inputs at once. In both cases the clear must win over the set. The bench provokes this by sweeping every selection code against every starting state (idle, UP, DOWN) and every edge combination. It compares all three pins against the flag state, which it computes arithmetically from R1 to R3. The second is power-save or forced reset coinciding with a pending flag and with fresh edges. The bench judges this by looking for outputs off in the same cycle and no flag left once the input is released.

// File: rtl/pd_pkg.sv
package pd_pkg;
  localparam int unsigned NUM_IN = 2;
  localparam int unsigned SEL_W  = 2;
  localparam int unsigned IDX_REF = 0;
  localparam int unsigned IDX_FB  = 1;
  localparam int unsigned SEL_CMB = 1;
  localparam int unsigned SEL_EXT = 0;

  typedef struct packed {
    logic up;
    logic dn;
  } pd_flags_t;
endpackage

// File: rtl/pd_edge_det.sv
module pd_edge_det #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[i] <= 1'b0;
      else        prev_q[i] <= lvl[i];
    end
    assign rise[i] = lvl[i] & ~prev_q[i];
  end
endmodule

// File: rtl/pd_core.sv
module pd_core
  import pd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      hold,
  input  logic      ref_rise,
  input  logic      fb_rise,
  output pd_flags_t flags
);
  pd_flags_t flags_q;
  logic up_nx, dn_nx;

  always_comb begin
    up_nx = flags_q.up | ref_rise;
    dn_nx = flags_q.dn | fb_rise;
    if (up_nx && dn_nx) begin
      up_nx = 1'b0;
      dn_nx = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    flags_q <= '0;
    else if (hold) flags_q <= '0;
    else           flags_q <= '{up: up_nx, dn: dn_nx};
  end

  assign flags = flags_q;

  a_r2_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(flags_q.up && flags_q.dn));
  a_r1_up_set: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_rise && !fb_rise && !flags_q.dn && !hold) |=> flags_q.up);
  a_r1_dn_set: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_rise && !ref_rise && !flags_q.up && !hold) |=> flags_q.dn);
  a_r3_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_rise && fb_rise) |=> (!flags_q.up && !flags_q.dn));
  a_r7_hold_clears: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (!flags_q.up && !flags_q.dn));
endmodule

// File: rtl/pd_drive.sv
module pd_drive
  import pd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  pd_flags_t        flags,
  input  logic [SEL_W-1:0] sel,
  input  logic             off,
  output logic             cmb_drv,
  output logic             cmb_oe,
  output logic             pup_oe,
  output logic             pdn_oe
);
  logic cmb_en, ext_en;

  assign cmb_en  = sel[SEL_CMB] & ~off;
  assign ext_en  = sel[SEL_EXT] & ~off;
  assign cmb_drv = flags.up;
  assign cmb_oe  = cmb_en & (flags.up | flags.dn);
  assign pup_oe  = ext_en & flags.up;
  assign pdn_oe  = ext_en & flags.dn;

  a_r7_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    off |-> (!cmb_oe && !pup_oe && !pdn_oe));
  a_r5_pair_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(pup_oe && pdn_oe));
  a_r4_float_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!flags.up && !flags.dn) |-> !cmb_oe);
  a_r6_ext_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !sel[SEL_EXT] |-> (!pup_oe && !pdn_oe));
endmodule

// File: rtl/pd_out_stage.sv
module pd_out_stage
  import pd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_in,
  input  logic             fb_in,
  input  logic [SEL_W-1:0] cp_sel,
  input  logic             pwr_save,
  input  logic             force_rst,
  output logic             cmb_drv,
  output logic             cmb_oe,
  output logic             pup_oe,
  output logic             pdn_oe
);
  logic [NUM_IN-1:0] lvl, rise;
  pd_flags_t         flags;
  logic              off;

  assign lvl[IDX_REF] = ref_in;
  assign lvl[IDX_FB]  = fb_in;
  assign off          = pwr_save | force_rst;

  pd_edge_det #(.N(NUM_IN)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .rise(rise)
  );

  pd_core u_core (
    .clk(clk), .rst_n(rst_n), .hold(off),
    .ref_rise(rise[IDX_REF]), .fb_rise(rise[IDX_FB]), .flags(flags)
  );

  pd_drive u_drv (
    .clk(clk), .rst_n(rst_n), .flags(flags), .sel(cp_sel), .off(off),
    .cmb_drv(cmb_drv), .cmb_oe(cmb_oe), .pup_oe(pup_oe), .pdn_oe(pdn_oe)
  );

  a_r8_force_off: assert property (@(posedge clk) disable iff (!rst_n)
    force_rst |-> (!cmb_oe && !pup_oe && !pdn_oe));
endmodule

// File: tb/pd_out_stage_tb.sv
module pd_out_stage_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ref_in = 1'b0, fb_in = 1'b0, pwr_save = 1'b0, force_rst = 1'b0;
  logic [1:0] cp_sel = 2'b11;
  logic cmb_drv, cmb_oe, pup_oe, pdn_oe;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pd_out_stage u_dut (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in), .cp_sel(cp_sel),
    .pwr_save(pwr_save), .force_rst(force_rst),
    .cmb_drv(cmb_drv), .cmb_oe(cmb_oe), .pup_oe(pup_oe), .pdn_oe(pdn_oe)
  );

  // Pin view: {cmb_oe, value driven while enabled, pup_oe, pdn_oe}
  function automatic logic [3:0] expect_pins(bit up, bit dn, logic [1:0] sel, bit off);
    bit ce = sel[1] && !off;
    bit ee = sel[0] && !off;
    return {ce && (up || dn), ce && up, ee && up, ee && dn};
  endfunction

  task automatic check(string tag, logic [3:0] exp);
    logic [3:0] got = {cmb_oe, cmb_oe & cmb_drv, pup_oe, pdn_oe};
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: pins got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_state();
    force_rst = 1'b1;
    cyc();
    force_rst = 1'b0;
  endtask

  task automatic pulse(bit r, bit f);
    ref_in = r;
    fb_in  = f;
    cyc();
    ref_in = 1'b0;
    fb_in  = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    cyc();
    check("R9 outputs off in reset", 4'b0000);
    rst_n = 1'b1;
    cyc();
    check("R9 outputs off after reset release", 4'b0000);

    // Sweep: selection code x starting state x edge combination (R1 to R6)
    for (int sel = 0; sel < 4; sel++) begin
      for (int prep = 0; prep < 3; prep++) begin
        for (int cmb = 0; cmb < 4; cmb++) begin
          bit up, dn, re, fe, un, dnx;
          clear_state();
          cp_sel = sel[1:0];
          up = (prep == 1);
          dn = (prep == 2);
          pulse(prep == 1, prep == 2);
          cyc();
          check($sformatf("R1 R6 prep sel=%0d prep=%0d", sel, prep),
                expect_pins(up, dn, sel[1:0], 1'b0));
          re = cmb[1];
          fe = cmb[0];
          pulse(re, fe);
          un  = up | re;
          dnx = dn | fe;
          if (un && dnx) begin un = 1'b0; dnx = 1'b0; end
          check($sformatf("%s R4 R5 R6 sel=%0d prep=%0d edges=%0d",
                (re && fe) ? "R3" : ((up && fe) || (dn && re)) ? "R2" : "R1",
                sel, prep, cmb), expect_pins(un, dnx, sel[1:0], 1'b0));
        end
      end
    end

    // R7: power-save forces off at once, clears, ignores edges
    cp_sel = 2'b11;
    clear_state();
    pulse(1'b1, 1'b0);
    check("R7 UP before power-save", expect_pins(1, 0, 2'b11, 0));
    pwr_save = 1'b1;
    #1;
    check("R7 off in same cycle", 4'b0000);
    @(negedge clk);
    pulse(1'b0, 1'b1);
    check("R7 off with edge during power-save", 4'b0000);
    pwr_save = 1'b0;
    cyc();
    check("R7 no flag after power-save", 4'b0000);

    // R8: forced reset with DOWN pending
    pulse(1'b0, 1'b1);
    check("R8 DOWN before forced reset", expect_pins(0, 1, 2'b11, 0));
    force_rst = 1'b1;
    #1;
    check("R8 off in same cycle", 4'b0000);
    @(negedge clk);
    force_rst = 1'b0;
    cyc();
    check("R8 flags clear after forced reset", 4'b0000);

    // R10: held-high reference produces one edge only
    ref_in = 1'b1;
    cyc();
    check("R10 first edge sets UP", expect_pins(1, 0, 2'b11, 0));
    fb_in = 1'b1;
    cyc();
    fb_in = 1'b0;
    check("R10 cleared by feedback", 4'b0000);
    repeat (3) cyc();
    check("R10 held level does not retrigger", 4'b0000);
    ref_in = 1'b0;
    cyc();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule